// File: doc/BRIEF.md
# Keyed Scrambling SRAM Controller with Terminal Lock

This block sits between a simple single-cycle memory request port and an external single-port SRAM array. Every address is remapped through a keyed bijection and every data word is masked with a keystream derived from the key, the nonce and the logical address. Each stored word carries one parity bit per byte, computed over the masked data, and parity is checked on every read. The key and nonce start at zero after reset and are replaced by fetching a fresh pair over a request/acknowledge handshake from a key-provider port. Requests that arrive while such a fetch is outstanding are discarded.

Two events put the controller into a terminal lock that only a reset clears: an escalation input, and a parity mismatch on a read. Escalation also wipes the key and nonce. A parity mismatch records the logical address of the failing read and raises an alert. A separate command sweeps the whole array with masked zero words so that every location reads back as zero under the current key.

Top module: `scr_sram_ctrl`

## Requirements
- R1: After reset `locked`, `alert`, `key_valid`, `key_pending`, `init_done` and `rsp_valid` are 0, and with the all-zero key the physical address `mem_addr` equals the logical address of a write.
- R2: A word written under a given key and nonce reads back unchanged under that key and nonce, including the all-zero key and after any number of key changes.
- R3: A one-cycle `key_refresh` pulse raises `key_req` and `key_pending` in the next cycle. `key_req` stays high until `key_ack` is sampled. `key_pending` stays high for one more cycle and then falls, with `key_valid` equal to the sampled `key_seed_ok`. A fetch with `key_seed_ok` = 0 leaves the key and nonce unchanged.
- R4: A request accepted while `key_pending` is high produces no `mem_en` cycle and no `rsp_valid`.
- R5: For every key the address mapping is a bijection: all logical addresses land on distinct physical addresses, and each address reads back its own value.
- R6: An `escalate` pulse sets `locked` at the next edge and clears `key_valid`. A request in the same cycle is also blocked. Afterwards no request reaches the array, `key_refresh` raises no `key_req`, and only reset restores normal operation.
- R7: Bit DATA_W+b of a stored word is the even-parity bit of data byte b (bits 8b+7..8b). A read whose word fails this check gives no `rsp_valid`, sets `alert` and `locked`, and sets `err_addr` to the logical address of that read. Further accesses are then blocked until reset.
- R8: A write followed in the very next cycle by a read of the same address returns the newly written data.
- R9: An accepted `init_start` produces exactly 2^ADDR_W consecutive array writes and then sets `init_done`. Requests during the sweep are dropped, and afterwards every address reads 0.
- R10: A read issued in cycle t gives `rsp_valid` and `rsp_rdata` in cycle t+2 and not in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Unmasked read data |
| key_refresh | input | 1 | Start a key fetch |
| key_req | output | 1 | Key request to the provider |
| key_ack | input | 1 | Provider acknowledge, key fields valid |
| key_data | input | KEY_W | Key from the provider |
| nonce_data | input | NONCE_W | Nonce from the provider |
| key_seed_ok | input | 1 | Provider marks key and seed valid |
| key_pending | output | 1 | Fetch in progress |
| key_valid | output | 1 | Current key came from a valid fetch |
| init_start | input | 1 | Start the zeroing sweep |
| init_done | output | 1 | Sweep finished |
| escalate | input | 1 | Escalation request, latched |
| locked | output | 1 | Terminal lock state |
| alert | output | 1 | Parity fault alert |
| err_addr | output | ADDR_W | Logical address of the failing read |
| mem_en | output | 1 | Array enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Physical array address |
| mem_wdata | output | DATA_W+DATA_W/8 | Masked data with per-byte parity |
| mem_rdata | input | DATA_W+DATA_W/8 | Array read data, one cycle after the read |

## Verification
A wrong key or nonce register shows as read data that differs from what was written, as soon as the next read under that key. A broken address mapping shows as a collision among the observed physical addresses during a full sweep, or as an overwritten neighbour on readback. Lock or fetch-state faults show at the array enable: a request that should have been dropped makes a `mem_en` cycle in its own cycle, or a response two cycles later. A parity path fault shows in the cycle after the corrupted read as a missing `alert`, a wrong `err_addr`, or a response that should not exist.

// File: rtl/scr_pkg.sv
package scr_pkg;

    parameter int ADDR_W  = 6;
    parameter int DATA_W  = 32;
    parameter int KEY_W   = 64;
    parameter int NONCE_W = 32;

    localparam int NB    = DATA_W / 8;
    localparam int MEM_W = DATA_W + NB;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] MIX_K = DATA_W'(32'h9E37_79B1);

    typedef enum logic [1:0] {
        KF_IDLE = 2'd0,
        KF_REQ  = 2'd1,
        KF_LOAD = 2'd2
    } kf_state_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] laddr;
        logic [DATA_W-1:0] ks;
    } rd_ctx_t;

    // keyed bijection: xor with key bits, then a key-chosen rotation
    function automatic logic [ADDR_W-1:0] scr_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [KEY_W-1:0]  k);
        logic [ADDR_W-1:0] x;
        logic [ADDR_W-1:0] y;
        int                r;
        x = a ^ k[ADDR_W-1:0];
        r = int'(k[ADDR_W +: 8]) % ADDR_W;
        y = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            y[(i + r) % ADDR_W] = x[i];
        end
        return y;
    endfunction

    function automatic logic [DATA_W-1:0] scr_ks(input logic [ADDR_W-1:0]  a,
                                                 input logic [KEY_W-1:0]   k,
                                                 input logic [NONCE_W-1:0] n);
        logic [DATA_W-1:0] rep;
        logic [DATA_W-1:0] m;
        rep = '0;
        for (int i = 0; i < DATA_W; i++) begin
            rep[i] = a[i % ADDR_W];
        end
        m = k[KEY_W-1 -: DATA_W] ^ n[DATA_W-1:0] ^ (rep * MIX_K);
        return m ^ {m[DATA_W/2-1:0], m[DATA_W-1:DATA_W/2]};
    endfunction

    function automatic logic [NB-1:0] byte_par(input logic [DATA_W-1:0] d);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) begin
            p[b] = ^d[8*b +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/scr_keyfetch.sv
module scr_keyfetch
    import scr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               refresh,
    input  logic               clear,
    input  logic               ack,
    input  logic [KEY_W-1:0]   key_in,
    input  logic [NONCE_W-1:0] nonce_in,
    input  logic               seed_ok,
    output logic               key_req,
    output logic               pending,
    output logic [KEY_W-1:0]   key_q,
    output logic [NONCE_W-1:0] nonce_q,
    output logic               key_valid
);

    kf_state_e          state;
    logic [KEY_W-1:0]   stg_key;
    logic [NONCE_W-1:0] stg_nonce;
    logic               stg_ok;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state     <= KF_IDLE;
            key_q     <= '0;
            nonce_q   <= '0;
            key_valid <= 1'b0;
            stg_key   <= '0;
            stg_nonce <= '0;
            stg_ok    <= 1'b0;
        end else begin
            unique case (state)
                KF_IDLE: if (refresh) state <= KF_REQ;
                KF_REQ: begin
                    if (ack) begin
                        stg_key   <= key_in;
                        stg_nonce <= nonce_in;
                        stg_ok    <= seed_ok;
                        state     <= KF_LOAD;
                    end
                end
                KF_LOAD: begin
                    if (stg_ok) begin
                        key_q   <= stg_key;
                        nonce_q <= stg_nonce;
                    end
                    key_valid <= stg_ok;
                    state     <= KF_IDLE;
                end
                default: state <= KF_IDLE;
            endcase
        end
    end

    assign key_req = (state == KF_REQ);
    assign pending = (state != KF_IDLE);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (key_req && !ack && !clear) |=> key_req);

    assert_ack_load_R3: assert property (@(posedge clk) disable iff (rst)
        (key_req && ack && !clear) |=> (pending && !key_req));

    assert_clear_wipe_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!key_valid && !pending && key_q == '0));

endmodule

// File: rtl/scr_lock.sv
module scr_lock
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              escalate,
    input  logic              par_err,
    input  logic [ADDR_W-1:0] fail_addr,
    output logic              locked,
    output logic              alert,
    output logic [ADDR_W-1:0] err_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            alert    <= 1'b0;
            err_addr <= '0;
        end else begin
            if (escalate) locked <= 1'b1;
            if (par_err && !locked) begin
                locked   <= 1'b1;
                alert    <= 1'b1;
                err_addr <= fail_addr;
            end
        end
    end

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    assert_esc_latch_R6: assert property (@(posedge clk) disable iff (rst)
        escalate |=> locked);

    assert_alert_locks_R7: assert property (@(posedge clk) disable iff (rst)
        alert |-> locked);

    assert_erraddr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (alert && $past(alert)) |-> $stable(err_addr));

endmodule

// File: rtl/scr_init.sv
module scr_init
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            addr <= '0;
            done <= 1'b0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            addr <= '0;
            done <= 1'b0;
        end else if (busy) begin
            addr <= addr + 1'b1;
            if (addr == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assert_sweep_step_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (addr == $past(addr) + 1'b1));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && $past(addr) == LAST));

endmodule

// File: rtl/scr_sram_ctrl.sv
module scr_sram_ctrl
    import scr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic               key_refresh,
    output logic               key_req,
    input  logic               key_ack,
    input  logic [KEY_W-1:0]   key_data,
    input  logic [NONCE_W-1:0] nonce_data,
    input  logic               key_seed_ok,
    output logic               key_pending,
    output logic               key_valid,
    input  logic               init_start,
    output logic               init_done,
    input  logic               escalate,
    output logic               locked,
    output logic               alert,
    output logic [ADDR_W-1:0]  err_addr,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [MEM_W-1:0]   mem_wdata,
    input  logic [MEM_W-1:0]   mem_rdata
);

    logic [KEY_W-1:0]   key_q;
    logic [NONCE_W-1:0] nonce_q;
    logic               lock_now;
    logic               init_busy;
    logic [ADDR_W-1:0]  init_addr;
    logic               init_go;
    logic               init_wr;
    logic               acc_ok;
    logic [ADDR_W-1:0]  laddr;
    logic [DATA_W-1:0]  plain;
    logic [DATA_W-1:0]  ks;
    logic [DATA_W-1:0]  sdata;
    logic [NB-1:0]      chk;
    logic               par_bad;
    rd_ctx_t            rd_q;

    assign lock_now = locked | escalate;

    scr_keyfetch u_kf (
        .clk       (clk),
        .rst       (rst),
        .refresh   (key_refresh & ~init_busy & ~lock_now),
        .clear     (lock_now),
        .ack       (key_ack),
        .key_in    (key_data),
        .nonce_in  (nonce_data),
        .seed_ok   (key_seed_ok),
        .key_req   (key_req),
        .pending   (key_pending),
        .key_q     (key_q),
        .nonce_q   (nonce_q),
        .key_valid (key_valid)
    );

    assign init_go = init_start & ~key_pending & ~key_refresh & ~lock_now;

    scr_init u_init (
        .clk   (clk),
        .rst   (rst),
        .start (init_go),
        .abort (lock_now),
        .busy  (init_busy),
        .addr  (init_addr),
        .done  (init_done)
    );

    assign acc_ok  = req_valid & ~lock_now & ~key_pending & ~init_busy;
    assign init_wr = init_busy & ~lock_now;

    always_comb begin
        laddr     = init_wr ? init_addr : req_addr;
        plain     = init_wr ? '0 : req_wdata;
        ks        = scr_ks(laddr, key_q, nonce_q);
        sdata     = plain ^ ks;
        mem_wdata = {byte_par(sdata), sdata};
        mem_addr  = scr_addr(laddr, key_q);
        mem_en    = init_wr | acc_ok;
        mem_we    = init_wr | (acc_ok & req_write);
    end

    for (genvar b = 0; b < NB; b++) begin : g_par
        assign chk[b] = ^{mem_rdata[8*b +: 8], mem_rdata[DATA_W + b]};
    end

    assign par_bad = rd_q.vld & (|chk);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rd_q.vld   <= acc_ok & ~req_write;
            rd_q.laddr <= req_addr;
            rd_q.ks    <= ks;
            rsp_valid  <= rd_q.vld & ~(|chk) & ~lock_now;
            rsp_rdata  <= mem_rdata[DATA_W-1:0] ^ rd_q.ks;
        end
    end

    scr_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .escalate  (escalate),
        .par_err   (par_bad),
        .fail_addr (rd_q.laddr),
        .locked    (locked),
        .alert     (alert),
        .err_addr  (err_addr)
    );

    assert_pending_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        key_pending |-> !mem_en);

    assert_locked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        locked |-> (!mem_en && !key_req));

    assert_rsp_latency_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(mem_en && !mem_we, 2));

    assert_bad_no_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        par_bad |=> (!rsp_valid && locked));

endmodule

// File: tb/tb_scr_sram_ctrl.sv
`timescale 1ns/1ps
module tb_scr_sram_ctrl;
    import scr_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               rsp_valid;
    logic [DATA_W-1:0]  rsp_rdata;
    logic               key_refresh = 1'b0, key_ack = 1'b0, key_seed_ok = 1'b0;
    logic               key_req, key_pending, key_valid;
    logic [KEY_W-1:0]   key_data = '0;
    logic [NONCE_W-1:0] nonce_data = '0;
    logic               init_start = 1'b0, init_done;
    logic               escalate = 1'b0, locked, alert;
    logic [ADDR_W-1:0]  err_addr;
    logic               mem_en, mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [MEM_W-1:0]   mem_wdata;
    logic [MEM_W-1:0]   mem_rdata = '0;

    logic [MEM_W-1:0]   marr [DEPTH];
    logic               inj_en = 1'b0;
    logic [ADDR_W-1:0]  inj_addr = '0;
    logic [MEM_W-1:0]   inj_mask = '0;
    int                 wr_cnt = 0, rd_cnt = 0, par_err_cnt = 0;
    logic [ADDR_W-1:0]  last_phys = '0;
    int                 n_chk = 0, n_fail = 0;
    bit                 finished = 0;

    always #2.5 clk = ~clk;

    scr_sram_ctrl dut (.*);

    initial begin
        for (int i = 0; i < DEPTH; i++) marr[i] = '0;
    end

    // array model and port monitor
    always @(posedge clk) begin
        if (inj_en) marr[inj_addr] <= marr[inj_addr] ^ inj_mask;
        if (mem_en && mem_we) begin
            marr[mem_addr] <= mem_wdata;
            wr_cnt    <= wr_cnt + 1;
            last_phys <= mem_addr;
            for (int b = 0; b < NB; b++)
                if (^{mem_wdata[8*b +: 8], mem_wdata[DATA_W + b]}) par_err_cnt <= par_err_cnt + 1;
        end
        if (mem_en && !mem_we) begin
            mem_rdata <= marr[mem_addr];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 0; key_refresh = 0; key_ack = 0;
        init_start = 0; escalate = 0; inj_en = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        tick();
        req_valid = 0; req_write = 0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic v, output logic [DATA_W-1:0] d);
        req_valid = 1; req_write = 0; req_addr = a;
        tick();
        req_valid = 0;
        check(rsp_valid == 1'b0, "R10 no response after one edge", 64'(rsp_valid), 64'd0);
        tick();
        v = rsp_valid; d = rsp_rdata;
    endtask

    task automatic read_expect(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        logic v; logic [DATA_W-1:0] d;
        do_read(a, v, d);
        check(v == 1'b1, tag, 64'(v), 64'd1);
        check(d == e, tag, 64'(d), 64'(e));
    endtask

    task automatic fetch_key(input logic [KEY_W-1:0] k, input logic [NONCE_W-1:0] n,
                             input logic ok, input bit poke);
        int w0, r0;
        logic v; logic [DATA_W-1:0] d;
        key_refresh = 1;
        tick();
        key_refresh = 0;
        check(key_req && key_pending, "R3 request raised", {key_req, key_pending}, 2'b11);
        tick(); tick();
        check(key_req == 1'b1, "R3 request held", 64'(key_req), 64'd1);
        if (poke) begin
            w0 = wr_cnt; r0 = rd_cnt;
            do_write(6'd5, 32'hDEAD_0005);
            do_read(6'd5, v, d);
            check(v == 1'b0, "R4 read dropped while pending", 64'(v), 64'd0);
            check(wr_cnt == w0 && rd_cnt == r0, "R4 array untouched while pending",
                  64'(wr_cnt - w0 + rd_cnt - r0), 64'd0);
        end
        key_ack = 1; key_data = k; nonce_data = n; key_seed_ok = ok;
        tick();
        key_ack = 0;
        check(!key_req && key_pending, "R3 load cycle", {key_req, key_pending}, 2'b01);
        tick();
        check(!key_pending && key_valid == ok, "R3 fetch complete",
              {key_pending, key_valid}, {1'b0, ok});
    endtask

    task automatic random_traffic(input int n);
        logic [DATA_W-1:0] shadow [DEPTH];
        logic [DEPTH-1:0]  have;
        have = '0;
        for (int i = 0; i < n; i++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            if (!have[a] || ($urandom % 2) == 0) begin
                shadow[a] = $urandom;
                have[a] = 1'b1;
                do_write(a, shadow[a]);
            end else begin
                read_expect(a, shadow[a], "R2 random round trip");
            end
        end
    endtask

    task automatic bijection_pass();
        logic [DEPTH-1:0] seen;
        int coll;
        seen = '0; coll = 0;
        for (int a = 0; a < DEPTH; a++) begin
            do_write(ADDR_W'(a), 32'hA500_0000 | a);
            if (seen[last_phys]) coll++;
            seen[last_phys] = 1'b1;
        end
        check(coll == 0 && &seen, "R5 distinct physical addresses", 64'(coll), 64'd0);
        for (int a = 0; a < DEPTH; a++)
            read_expect(ADDR_W'(a), 32'hA500_0000 | a, "R5 address readback");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic v; logic [DATA_W-1:0] d;
        int w0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1 reset state and identity map under zero key
        check({locked, alert, key_valid, key_pending, init_done, rsp_valid} == 6'b0,
              "R1 reset outputs", {locked, alert, key_valid, key_pending, init_done, rsp_valid}, 0);
        do_write(6'd23, 32'h1234_5678);
        check(last_phys == 6'd23, "R1 zero key identity address", 64'(last_phys), 64'd23);
        read_expect(6'd23, 32'h1234_5678, "R2 zero key round trip");
        random_traffic(40);

        // R9 zeroing sweep with a dropped request inside it
        w0 = wr_cnt;
        init_start = 1;
        tick();
        init_start = 0;
        do_read(6'd3, v, d);
        check(v == 1'b0, "R9 request dropped during sweep", 64'(v), 64'd0);
        for (int i = 0; i < 200 && !init_done; i++) tick();
        check(init_done == 1'b1, "R9 done flag", 64'(init_done), 64'd1);
        check(wr_cnt - w0 == DEPTH, "R9 sweep write count", 64'(wr_cnt - w0), 64'(DEPTH));
        for (int i = 0; i < 4; i++) read_expect(ADDR_W'($urandom), '0, "R9 zero after sweep");

        // R3/R4 fetch with accesses while pending, then R2/R5 under several keys
        fetch_key(64'h0123_4567_89AB_CDEF, 32'h5A5A_1234, 1'b1, 1'b1);
        random_traffic(60);
        bijection_pass();
        for (int k = 0; k < 3; k++) begin
            fetch_key({$urandom, $urandom}, $urandom, 1'b1, 1'b0);
            random_traffic(40);
            bijection_pass();
        end

        // R3 invalid seed leaves the key in place
        do_write(6'd40, 32'hCAFE_F00D);
        fetch_key(64'hFFFF_0000_FFFF_0000, 32'h1111_2222, 1'b0, 1'b0);
        read_expect(6'd40, 32'hCAFE_F00D, "R3 invalid seed keeps key");

        // R8 back-to-back write then read, same address
        for (int i = 0; i < 4; i++) begin
            logic [ADDR_W-1:0] a; logic [DATA_W-1:0] x;
            a = ADDR_W'($urandom); x = $urandom;
            do_write(a, ~x);
            req_valid = 1; req_write = 1; req_addr = a; req_wdata = x;
            tick();
            req_write = 0;
            tick();
            req_valid = 0;
            tick();
            check(rsp_valid && rsp_rdata == x, "R8 read after write", 64'(rsp_rdata), 64'(x));
        end

        // R6 escalation
        w0 = wr_cnt;
        escalate = 1; req_valid = 1; req_write = 1; req_addr = 6'd9; req_wdata = 32'h9;
        tick();
        escalate = 0; req_valid = 0; req_write = 0;
        check(locked && !key_valid, "R6 latched and key cleared", {locked, key_valid}, 2'b10);
        check(wr_cnt == w0, "R6 same-cycle write blocked", 64'(wr_cnt - w0), 64'd0);
        do_read(6'd9, v, d);
        check(v == 1'b0, "R6 read blocked", 64'(v), 64'd0);
        key_refresh = 1;
        tick();
        key_refresh = 0;
        check(key_req == 1'b0 && locked, "R6 no key request when locked", 64'(key_req), 64'd0);
        do_reset();
        check(!locked, "R6 reset clears lock", 64'(locked), 64'd0);
        fetch_key(64'h7777_8888_9999_AAAA, 32'h0F0F_0F0F, 1'b1, 1'b0);
        do_write(6'd17, 32'h0BAD_BEEF);
        read_expect(6'd17, 32'h0BAD_BEEF, "R6 recovery round trip");

        // R7 parity fault
        check(par_err_cnt == 0, "R7 stored parity field", 64'(par_err_cnt), 64'd0);
        do_write(6'd33, 32'h4242_4242);
        inj_addr = last_phys; inj_mask = MEM_W'(1) << 10; inj_en = 1;
        tick();
        inj_en = 0;
        do_read(6'd33, v, d);
        check(v == 1'b0, "R7 no response on bad parity", 64'(v), 64'd0);
        check(alert && locked, "R7 alert and lock", {alert, locked}, 2'b11);
        check(err_addr == 6'd33, "R7 failing address", 64'(err_addr), 64'd33);
        w0 = wr_cnt;
        do_write(6'd1, 32'h1);
        check(wr_cnt == w0, "R7 write blocked after fault", 64'(wr_cnt - w0), 64'd0);
        do_reset();
        check(!alert && !locked, "R7 reset clears fault", {alert, locked}, 2'b00);
        do_write(6'd2, 32'h2222);
        read_expect(6'd2, 32'h2222, "R7 recovery round trip");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule